// File: doc/BRIEF.md
# Cascadable Automaton Counter Element

This block counts activation events coming from automaton state elements and raises a single activation output when a programmed target count is reached. Pattern engines use it for bounded repetition (for example "between N and M occurrences of a class") and for one-shot pruning, where a path through a cycle of states may be followed only once.

The count-enable and the synchronous clear are each formed from a bank of incoming activation lines, with a per-line select mask for each role. The counter is built from 12-bit segments. A span setting chains one to four segments into a counter of 12 to 48 bits. Three output behaviours are available: a single pulse that then stays silent, a level that holds until cleared, and a pulse that also reloads the count to zero. An active-low asynchronous reset overrides everything.

Top module: `cascade_counter_elem`

## Requirements
- R1: While `arst_n` is low, `act_out` is 0 at once, without waiting for a clock edge. After release, counting restarts from zero and any earlier pulse history is forgotten.
- R2: The count-enable is the OR of the `act_lines` bits whose `cfg_cnt_sel` bit is 1. A line whose select bit is 0 has no effect on the count or on `act_out`.
- R3: The synchronous clear is the OR of the `act_lines` bits whose `cfg_clr_sel` bit is 1. At the next rising edge it zeroes the count and `act_out` and re-arms pulse mode. It wins over a count-enable in the same cycle.
- R4: Each rising edge with the count-enable high advances the count by one. `act_out` is registered: it is high in the cycle that follows the enabled edge at which the count becomes equal to the target.
- R5: With `cfg_mode` 0, `act_out` is high for exactly one cycle on reaching the target and stays low until a clear or reset, even if the count wraps and passes the target again. Code 3 behaves the same as code 0.
- R6: With `cfg_mode` 1, `act_out` stays high from reaching the target until a clear or reset. The count holds at the target, and further enables change nothing.
- R7: With `cfg_mode` 2, `act_out` pulses for one cycle on reaching the target, and the count returns to zero at the same edge. The next pulse therefore follows after another target-many enables.
- R8: `cfg_span` = k chains k+1 segments of 12 bits, with segment 0 in the low bits. A segment passes a carry to the next segment when it rolls over. The compare uses the whole chained value, target bits above the active width are ignored, and the count wraps at 2^(12(k+1)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous reset, active low, overriding |
| act_lines | input | NUM_LINES | Incoming activation lines |
| cfg_cnt_sel | input | NUM_LINES | Lines that act as the count-enable |
| cfg_clr_sel | input | NUM_LINES | Lines that act as the synchronous clear |
| cfg_mode | input | 2 | 0 pulse, 1 level, 2 pulse with reload, 3 same as 0 |
| cfg_span | input | SPAN_W | Number of chained segments minus one |
| cfg_target | input | SEG_W*MAX_SEGS | Target count; segment 0 in the low bits |
| act_out | output | 1 | Activation output |

## Verification
Every synchronous result is due exactly one cycle after the rising edge that sampled its stimulus, because `act_out` is the only register on the output path. The bench drives inputs on the falling edge. A behavioural model updates its own count at each rising edge, and the output is compared with the model at the next falling edge. This keeps each comparison half a cycle away from the edge that changes the output. The asynchronous reset is the one result with no clock between stimulus and effect, so it is checked half a nanosecond after `arst_n` falls, between two edges.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
   typedef enum logic [1:0] {
      CTR_PULSE  = 2'd0,
      CTR_LEVEL  = 2'd1,
      CTR_RELOAD = 2'd2,
      CTR_SPARE  = 2'd3
   } ctr_mode_e;
endpackage

// File: rtl/ctr_line_sel.sv
module ctr_line_sel #(
   parameter int NUM_LINES = 4
) (
   input  logic [NUM_LINES-1:0] lines,
   input  logic [NUM_LINES-1:0] mask,
   output logic                 hit
);
   assign hit = |(lines & mask);
endmodule

// File: rtl/ctr_segment.sv
module ctr_segment #(
   parameter int SEG_W = 12
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             clr,
   input  logic             live,
   input  logic             adv,
   input  logic             cin,
   output logic [SEG_W-1:0] inc_val
);
   logic [SEG_W-1:0] q;

   // value this segment would hold after an advance; zero when not chained
   assign inc_val = live ? (q + {{(SEG_W-1){1'b0}}, cin}) : '0;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)          q <= '0;
      else if (clr || !live) q <= '0;
      else if (adv)          q <= inc_val;
   end
endmodule

// File: rtl/ctr_fire.sv
module ctr_fire
   import ctr_pkg::*;
(
   input  logic       clk,
   input  logic       arst_n,
   input  logic [1:0] mode,
   input  logic       ce,
   input  logic       clr,
   input  logic       hit,
   output logic       adv,
   output logic       seg_clr,
   output logic       act_out
);
   ctr_mode_e m;
   logic out_q, spent_q, out_d, spent_d;
   logic fire_once, fire_any;

   assign m         = ctr_mode_e'(mode);
   assign fire_any  = ce & hit;
   assign fire_once = fire_any & ~spent_q;

   always_comb begin
      adv     = ce;
      out_d   = fire_once;
      spent_d = spent_q | fire_once;
      seg_clr = clr;
      unique case (m)
         CTR_LEVEL: begin
            adv     = ce & ~out_q;
            out_d   = out_q | (adv & hit);
            spent_d = spent_q;
         end
         CTR_RELOAD: begin
            out_d   = fire_any;
            spent_d = spent_q;
            seg_clr = clr | fire_any;
         end
         default: ;
      endcase
      if (clr) begin
         out_d   = 1'b0;
         spent_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         out_q   <= 1'b0;
         spent_q <= 1'b0;
      end else begin
         out_q   <= out_d;
         spent_q <= spent_d;
      end
   end

   assign act_out = out_q;
endmodule

// File: rtl/cascade_counter_elem.sv
module cascade_counter_elem
   import ctr_pkg::*;
#(
   parameter int SEG_W     = 12,
   parameter int MAX_SEGS  = 4,
   parameter int NUM_LINES = 4,
   localparam int SPAN_W   = (MAX_SEGS > 1) ? $clog2(MAX_SEGS) : 1,
   localparam int TOT_W    = SEG_W * MAX_SEGS
) (
   input  logic                 clk,
   input  logic                 arst_n,
   input  logic [NUM_LINES-1:0] act_lines,
   input  logic [NUM_LINES-1:0] cfg_cnt_sel,
   input  logic [NUM_LINES-1:0] cfg_clr_sel,
   input  logic [1:0]           cfg_mode,
   input  logic [SPAN_W-1:0]    cfg_span,
   input  logic [TOT_W-1:0]     cfg_target,
   output logic                 act_out
);
   if (SEG_W < 2) begin : g_bad_seg
      $error("SEG_W must be at least 2");
   end
   if (MAX_SEGS < 1 || MAX_SEGS > 4) begin : g_bad_segs
      $error("MAX_SEGS must be 1 to 4");
   end
   if (NUM_LINES < 1) begin : g_bad_lines
      $error("NUM_LINES must be at least 1");
   end

   logic ce, clr, hit, adv, seg_clr;
   logic [MAX_SEGS-1:0] carry;
   logic [TOT_W-1:0]    inc_all, tgt_eff;

   ctr_line_sel #(.NUM_LINES(NUM_LINES)) u_cnt_sel (
      .lines(act_lines), .mask(cfg_cnt_sel), .hit(ce));
   ctr_line_sel #(.NUM_LINES(NUM_LINES)) u_clr_sel (
      .lines(act_lines), .mask(cfg_clr_sel), .hit(clr));

   for (genvar g = 0; g < MAX_SEGS; g++) begin : g_seg
      logic seg_live;
      assign seg_live = (int'(cfg_span) >= g);

      if (g == 0) begin : g_base
         assign carry[g] = 1'b1;
      end else begin : g_link
         // rollover of the lower segment is seen as its advanced value reaching zero
         assign carry[g] = carry[g-1] & (inc_all[(g-1)*SEG_W +: SEG_W] == '0);
      end

      assign tgt_eff[g*SEG_W +: SEG_W] = seg_live ? cfg_target[g*SEG_W +: SEG_W] : '0;

      ctr_segment #(.SEG_W(SEG_W)) u_seg (
         .clk     (clk),
         .arst_n  (arst_n),
         .clr     (seg_clr),
         .live    (seg_live),
         .adv     (adv),
         .cin     (carry[g]),
         .inc_val (inc_all[g*SEG_W +: SEG_W])
      );
   end

   assign hit = (inc_all == tgt_eff);

   ctr_fire u_fire (
      .clk     (clk),
      .arst_n  (arst_n),
      .mode    (cfg_mode),
      .ce      (ce),
      .clr     (clr),
      .hit     (hit),
      .adv     (adv),
      .seg_clr (seg_clr),
      .act_out (act_out)
   );
endmodule

// File: rtl/cascade_counter_elem_chk.sv
module cascade_counter_elem_chk #(
   parameter int NUM_LINES = 4
) (
   input logic                 clk,
   input logic                 arst_n,
   input logic [NUM_LINES-1:0] act_lines,
   input logic [NUM_LINES-1:0] cfg_cnt_sel,
   input logic [NUM_LINES-1:0] cfg_clr_sel,
   input logic [1:0]           cfg_mode,
   input logic                 act_out
);
   logic ce_sel, clr_sel, pulse_now;
   assign ce_sel    = |(act_lines & cfg_cnt_sel);
   assign clr_sel   = |(act_lines & cfg_clr_sel);
   assign pulse_now = (cfg_mode == 2'd0) || (cfg_mode == 2'd3);

   assert_clear_quiet_R3: assert property (@(posedge clk) disable iff (!arst_n)
      clr_sel |=> !act_out);

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!arst_n)
      (cfg_mode != 2'd1 && !ce_sel) |=> !act_out);

   assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!arst_n)
      (pulse_now && ($past(cfg_mode) == 2'd0 || $past(cfg_mode) == 2'd3) && act_out)
      |=> !act_out);

   assert_level_hold_R6: assert property (@(posedge clk) disable iff (!arst_n)
      (cfg_mode == 2'd1 && $past(cfg_mode) == 2'd1 && act_out && !clr_sel)
      |=> act_out);
endmodule

bind cascade_counter_elem cascade_counter_elem_chk #(.NUM_LINES(NUM_LINES)) u_chk (
   .clk(clk), .arst_n(arst_n), .act_lines(act_lines), .cfg_cnt_sel(cfg_cnt_sel),
   .cfg_clr_sel(cfg_clr_sel), .cfg_mode(cfg_mode), .act_out(act_out));

// File: tb/cascade_counter_elem_bench.sv
`timescale 1ns/1ps
module cascade_counter_elem_bench;
   localparam int SEG_W = 12, MAX_SEGS = 4, NL = 4, SPAN_W = 2;
   localparam int TOT_W = SEG_W * MAX_SEGS;

   logic clk = 1'b0, arst_n = 1'b0;
   logic [NL-1:0] act_lines = '0, cfg_cnt_sel = 4'b0001, cfg_clr_sel = 4'b0010;
   logic [1:0] cfg_mode = 2'd0;
   logic [SPAN_W-1:0] cfg_span = '0;
   logic [TOT_W-1:0] cfg_target = 48'd5;
   logic act_out;

   int n_tests = 0, n_fail = 0;
   bit chk_on = 0;
   string tag = "R1";

   // reference model state
   logic [TOT_W-1:0] m_cnt;
   logic m_out, m_spent;

   always #2.5 clk = ~clk;

   cascade_counter_elem #(.SEG_W(SEG_W), .MAX_SEGS(MAX_SEGS), .NUM_LINES(NL)) u_cascade_counter_elem (
      .clk(clk), .arst_n(arst_n), .act_lines(act_lines), .cfg_cnt_sel(cfg_cnt_sel),
      .cfg_clr_sel(cfg_clr_sel), .cfg_mode(cfg_mode), .cfg_span(cfg_span),
      .cfg_target(cfg_target), .act_out(act_out));

   function automatic logic [TOT_W-1:0] wmask(input logic [SPAN_W-1:0] s);
      int w = SEG_W * (int'(s) + 1);
      logic [TOT_W-1:0] r = '0;
      for (int i = 0; i < TOT_W; i++) if (i < w) r[i] = 1'b1;
      return r;
   endfunction

   always @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         m_cnt = '0; m_out = 0; m_spent = 0;
      end else begin
         logic ce, rc;
         logic [TOT_W-1:0] mk, n, t;
         ce = |(act_lines & cfg_cnt_sel);
         rc = |(act_lines & cfg_clr_sel);
         mk = wmask(cfg_span);
         t  = cfg_target & mk;
         n  = (m_cnt + 1) & mk;
         if (rc) begin
            m_cnt = '0; m_out = 0; m_spent = 0;
         end else if (cfg_mode == 2'd1) begin
            if (ce && !m_out) begin
               m_cnt = n;
               if (n == t) m_out = 1;
            end
         end else if (cfg_mode == 2'd2) begin
            m_out = 0;
            if (ce) begin
               if (n == t) begin m_out = 1; m_cnt = '0; end
               else m_cnt = n;
            end
         end else begin
            m_out = 0;
            if (ce) begin
               m_cnt = n;
               if (n == t && !m_spent) begin m_out = 1; m_spent = 1; end
            end
         end
      end
   end

   task automatic check(input logic act, input logic exp, input string what);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s (%s): act_out=%b expected=%b at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (chk_on) check(act_out, m_out, "cycle compare");

   task automatic drive(input logic [NL-1:0] l, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); act_lines = l;
      end
   endtask

   task automatic setup(input logic [1:0] md, input logic [SPAN_W-1:0] sp,
                        input logic [TOT_W-1:0] tg, input logic [NL-1:0] cs);
      @(negedge clk);
      cfg_mode = md; cfg_span = sp; cfg_target = tg; cfg_cnt_sel = cs;
      act_lines = 4'b0010;
      @(negedge clk); act_lines = '0;
   endtask

   initial begin
      #(200000 * 5);
      n_tests++; n_fail++;
      $display("FAIL watchdog: act_out=%b expected=finish", act_out);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      tag = "R1"; check(act_out, 1'b0, "held in reset");
      arst_n = 1'b1; chk_on = 1;

      // R4 R5: pulse at 5th enable, then silence through a wrap of 4096
      tag = "R4 R5"; setup(2'd0, 2'd0, 48'd5, 4'b0001);
      drive(4'b0001, 5); drive(4'b0000, 3);
      tag = "R5"; drive(4'b0001, 4200);

      // R2: unselected lines ignored, then selected line counts
      tag = "R2"; setup(2'd0, 2'd0, 48'd3, 4'b0001);
      drive(4'b1100, 12); drive(4'b0001, 3); drive(4'b0000, 2);
      setup(2'd0, 2'd0, 48'd2, 4'b1000);
      drive(4'b0101, 6); drive(4'b1000, 2); drive(4'b0000, 2);

      // R6: level holds, count saturates, clear drops it
      tag = "R6"; setup(2'd1, 2'd0, 48'd3, 4'b0001);
      drive(4'b0001, 10); drive(4'b0000, 3); drive(4'b0010, 1);
      drive(4'b0001, 2); drive(4'b0000, 1); drive(4'b0001, 2);

      // R3: clear and count together, clear wins
      tag = "R3"; setup(2'd1, 2'd0, 48'd2, 4'b0001);
      drive(4'b0001, 1); drive(4'b0011, 1); drive(4'b0001, 1);
      drive(4'b0000, 2); drive(4'b0001, 1); drive(4'b0000, 2);
      setup(2'd0, 2'd0, 48'd1, 4'b0001);
      drive(4'b0001, 3); drive(4'b0011, 1); drive(4'b0001, 2); drive(4'b0000, 1);

      // R7: reload pulses every 4 enables, with gaps
      tag = "R7"; setup(2'd2, 2'd0, 48'd4, 4'b0001);
      for (int i = 0; i < 14; i++) drive((i % 3 == 2) ? 4'b0000 : 4'b0001, 1);
      drive(4'b0001, 8); drive(4'b0000, 2);

      // R5: code 3 acts as pulse
      tag = "R5 spare"; setup(2'd3, 2'd0, 48'd2, 4'b0001);
      drive(4'b0001, 6); drive(4'b0000, 1);

      // R8: two segments, carry across 4095 -> 4096
      tag = "R8"; setup(2'd2, 2'd1, 48'd4100, 4'b0001);
      drive(4'b0001, 8210); drive(4'b0000, 2);
      // one segment: upper target bits ignored (4100 acts as 4)
      setup(2'd0, 2'd0, 48'd4100, 4'b0001);
      drive(4'b0001, 10); drive(4'b0000, 1);
      // four segments, small target
      setup(2'd1, 2'd3, 48'd5, 4'b0001);
      drive(4'b0001, 7); drive(4'b0000, 1);

      // R1: asynchronous reset mid-count
      tag = "R1"; setup(2'd1, 2'd0, 48'd3, 4'b0001);
      drive(4'b0001, 4);
      #1 arst_n = 1'b0;
      #0.5 check(act_out, 1'b0, "async reset");
      @(negedge clk); arst_n = 1'b1;
      drive(4'b0001, 3); drive(4'b0000, 2);

      chk_on = 0;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule